// File: doc/BRIEF.md
# Interlaced Composite Video Sync Generator

This block is a raster timing engine. A horizontal counter steps once per pixel clock, and a line counter steps once per line. Both take their limits from 12-bit inputs that are held static while the block runs. From the two counters it derives horizontal and vertical sync, blanking, gating strobes, a cursor hit and a vertical interrupt. These signals are routed onto four shared output pins by select inputs. A fifth pin reports the current field.

Fields can be progressive, or they can be interlaced. In interlaced mode two fields of V + 1/2 lines make up one frame, and every even-field vertical event lands half a line later relative to the line boundaries. Composite sync can be a plain XOR of the horizontal and vertical sync. It can also be a shaped waveform, with equalizing pulses around the vertical interval and serrations inside it. All state changes on the falling edge of the clock. Clear re-initialises all counters. A build option decides whether counting starts on its own after clear or waits for a start strobe.

Top module: `vsg_sync_gen`

## Requirements
- R1: All outputs change only on the falling clock edge. While `rst_ni` is low the outputs are vcsync_o=0, vcblank_o=0, hmux_o=0, vmux_o=0 and field_o=1, and they take these values as soon as `rst_ni` falls.
- R2: With RUN_ON_CLEAR=1, counting starts at the first falling edge after reset. With RUN_ON_CLEAR=0, all outputs hold their reset values until `start_i` is seen high on a falling edge. At the second falling edge after that, the outputs show line position 0.
- R3: A line lasts `h_total_i` clocks, counted from 0. Horizontal sync is high while count < `h_sync_w_i`. Horizontal blank is high while count >= `h_blank_on_i` or count < `h_blank_off_i`.
- R4: A progressive field lasts `v_total_i` lines. Vertical sync is high on lines from `v_sync_on_i` up to but not including `v_sync_off_i`. Vertical blank is high on lines >= `v_blank_on_i` or < `v_blank_off_i`.
- R5: With `interlace_i`=1 a frame lasts 2*`v_total_i`+1 lines and each field lasts `v_total_i`+1/2 lines. field_o is 1 in the odd (first) field and 0 in the even field. All vertical events of the even field are delayed by half a line, which is `h_total_i`/2 clocks.
- R6: With `interlace_i`=0, field_o stays 1.
- R7: With `comp_sync_i`=0, vcsync_o is vertical sync. With `comp_sync_i`=1 and `eqser_en_i`=0, vcsync_o is horizontal sync XOR vertical sync.
- R8: With `comp_sync_i`=1 and `eqser_en_i`=1, vcsync_o follows one of three rules depending on the region.
  - Inside vertical sync it is high except during the last `h_sync_w_i` clocks of each half line.
  - In the EQ_HALVES half lines just before or just after vertical sync it is high for the first `h_sync_w_i`/2 clocks of each half line.
  - Elsewhere it is horizontal sync.
  - With `comp_sync_i`=0, `eqser_en_i` has no effect.
- R9: vcblank_o is vertical blank when `comp_blank_i`=0, and horizontal OR vertical blank when it is 1.
- R10: `hsel_i` selects hmux_o. 0 selects horizontal blank. 1 selects a gate that is high on count 0 of each line. 2 selects a cursor strobe, high when count = `h_cursor_i` and field line = `v_cursor_i`. 3 behaves as 0.
- R11: `vsel_i` selects vmux_o. 0 selects horizontal sync. 1 selects a gate that is high during the first line of each field, which is its first two half lines. 2 selects an interrupt that is high for one clock at the start of field half line 2*`v_blank_on_i`. 3 behaves as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; falling edge is active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| start_i | input | 1 | Starts counting when built with RUN_ON_CLEAR=0 |
| h_total_i | input | 12 | Clocks per line |
| h_sync_w_i | input | 12 | Horizontal sync width |
| h_blank_on_i | input | 12 | Count where horizontal blank begins |
| h_blank_off_i | input | 12 | Count where horizontal blank ends |
| h_cursor_i | input | 12 | Cursor column |
| v_total_i | input | 12 | Lines per field |
| v_sync_on_i | input | 12 | First vertical sync line |
| v_sync_off_i | input | 12 | Line after the last vertical sync line |
| v_blank_on_i | input | 12 | Line where vertical blank begins |
| v_blank_off_i | input | 12 | Line where vertical blank ends |
| v_cursor_i | input | 12 | Cursor line within the field |
| interlace_i | input | 1 | Interlaced fields |
| comp_sync_i | input | 1 | Composite on vcsync_o |
| comp_blank_i | input | 1 | Composite on vcblank_o |
| eqser_en_i | input | 1 | Equalizing and serration shaping enable |
| hsel_i | input | 2 | hmux_o function select |
| vsel_i | input | 2 | vmux_o function select |
| vcsync_o | output | 1 | Vertical or composite sync |
| vcblank_o | output | 1 | Vertical or composite blank |
| hmux_o | output | 1 | Horizontal blank, line gate or cursor |
| vmux_o | output | 1 | Horizontal sync, field gate or vertical interrupt |
| field_o | output | 1 | Field flag, high in the odd field |

## Verification
The bench goes after three timing details.

The first is the half-line shift of the even field. A design that resets its line count at the field boundary, instead of carrying on across a frame of 2V+1 lines, puts the even-field vertical sync on a line boundary and flips field_o half a line too early.

The second is shaped composite sync. If the equalizing window is counted in lines rather than half lines, the edges around vertical sync are misplaced. If shaping is not gated by composite mode, pulses leak onto plain vertical sync.

The third is the halted build. A design that updates its output registers while stopped shows line-position-0 values before the start strobe. A design that misses a counter register shifts every later edge by one clock.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    HSEL_BLANK  = 2'd0,
    HSEL_GATE   = 2'd1,
    HSEL_CURSOR = 2'd2
  } hsel_e;

  typedef enum logic [1:0] {
    VSEL_HSYNC = 2'd0,
    VSEL_GATE  = 2'd1,
    VSEL_IRQ   = 2'd2
  } vsel_e;

  typedef struct packed {
    logic vcsync;
    logic vcblank;
    logic hmux;
    logic vmux;
    logic field;
  } vsg_out_t;

  localparam vsg_out_t VSG_OUT_RST = '{vcsync: 1'b0, vcblank: 1'b0, hmux: 1'b0,
                                       vmux: 1'b0, field: 1'b1};
endpackage

// File: rtl/vsg_hcnt.sv
module vsg_hcnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] h_total_i,
  output logic [W-1:0] hcnt_o,
  output logic         line_end_o,
  output logic         second_o,
  output logic [W-1:0] hh_o
);
  logic [W-1:0] hcnt_q;
  logic [W-1:0] half;

  assign half       = h_total_i >> 1;
  assign line_end_o = (hcnt_q >= h_total_i - W'(1));
  assign second_o   = (hcnt_q >= half);
  assign hh_o       = second_o ? hcnt_q - half : hcnt_q;
  assign hcnt_o     = hcnt_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hcnt_q <= '0;
    else if (en_i) begin
      if (line_end_o)    hcnt_q <= '0;
      else               hcnt_q <= hcnt_q + W'(1);
    end
  end
endmodule

// File: rtl/vsg_vcnt.sv
module vsg_vcnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         line_end_i,
  input  logic         second_i,
  input  logic         interlace_i,
  input  logic [W-1:0] v_total_i,
  output logic [W+1:0] fhp_o,
  output logic         odd_o
);
  localparam int VW = W + 1;
  localparam int PW = W + 2;

  logic [VW-1:0] vcnt_q;
  logic [VW-1:0] frame_lines;
  logic [PW-1:0] fpos;
  logic [PW-1:0] odd_len;   // half lines in the odd field

  assign frame_lines = interlace_i ? {v_total_i, 1'b1} : {1'b0, v_total_i};
  assign fpos        = {vcnt_q, second_i};
  assign odd_len     = {1'b0, v_total_i, 1'b1};

  always_comb begin
    if (interlace_i && fpos >= odd_len) begin
      odd_o = 1'b0;
      fhp_o = fpos - odd_len;
    end else begin
      odd_o = 1'b1;
      fhp_o = fpos;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vcnt_q <= '0;
    else if (en_i && line_end_i) begin
      if (vcnt_q >= frame_lines - VW'(1)) vcnt_q <= '0;
      else                                vcnt_q <= vcnt_q + VW'(1);
    end
  end
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
  import vsg_pkg::*;
#(
  parameter int W         = 12,
  parameter int EQ_HALVES = 6
) (
  input  logic         h_total_lsb_ok_i,
  input  logic [W-1:0] h_total_i,
  input  logic [W-1:0] hcnt_i,
  input  logic [W-1:0] hh_i,
  input  logic [W+1:0] fhp_i,
  input  logic         odd_i,
  input  logic [W-1:0] h_sync_w_i,
  input  logic [W-1:0] h_blank_on_i,
  input  logic [W-1:0] h_blank_off_i,
  input  logic [W-1:0] h_cursor_i,
  input  logic [W-1:0] v_sync_on_i,
  input  logic [W-1:0] v_sync_off_i,
  input  logic [W-1:0] v_blank_on_i,
  input  logic [W-1:0] v_blank_off_i,
  input  logic [W-1:0] v_cursor_i,
  input  logic         comp_sync_i,
  input  logic         comp_blank_i,
  input  logic         eqser_en_i,
  input  logic [1:0]   hsel_i,
  input  logic [1:0]   vsel_i,
  output vsg_out_t     nxt_o
);
  localparam int XW = W + 3;

  logic [XW-1:0] fhp_x, vs2, ve2, vb_on2, vb_off2, eq_x;
  logic [W-1:0]  half;
  logic hsync, hblank, vsync, vblank, eq_zone, serr_lvl, eq_lvl, csync;
  logic hgate, cursor, vgate, virq;

  assign half    = h_total_i >> 1;
  assign fhp_x   = XW'(fhp_i);
  assign vs2     = {2'b00, v_sync_on_i, 1'b0};
  assign ve2     = {2'b00, v_sync_off_i, 1'b0};
  assign vb_on2  = {2'b00, v_blank_on_i, 1'b0};
  assign vb_off2 = {2'b00, v_blank_off_i, 1'b0};
  assign eq_x    = XW'(EQ_HALVES);

  assign hsync  = hcnt_i < h_sync_w_i;
  assign hblank = (hcnt_i >= h_blank_on_i) || (hcnt_i < h_blank_off_i);
  assign vsync  = (fhp_x >= vs2) && (fhp_x < ve2);
  assign vblank = (fhp_x >= vb_on2) || (fhp_x < vb_off2);

  // half lines bracketing the vertical sync interval
  assign eq_zone  = ((fhp_x + eq_x >= vs2) && (fhp_x < vs2)) ||
                    ((fhp_x >= ve2) && (fhp_x < ve2 + eq_x));
  assign serr_lvl = hh_i < (half - h_sync_w_i);
  assign eq_lvl   = hh_i < (h_sync_w_i >> 1);

  always_comb begin
    if (eqser_en_i) csync = vsync ? serr_lvl : (eq_zone ? eq_lvl : hsync);
    else            csync = hsync ^ vsync;
  end

  assign hgate  = hcnt_i == '0;
  assign cursor = (hcnt_i == h_cursor_i) && (fhp_i[W+1:1] == {1'b0, v_cursor_i});
  assign vgate  = fhp_x < XW'(2);
  assign virq   = (fhp_x == vb_on2) && (hh_i == '0) && h_total_lsb_ok_i;

  always_comb begin
    nxt_o.vcsync  = comp_sync_i ? csync : vsync;
    nxt_o.vcblank = comp_blank_i ? (hblank | vblank) : vblank;
    nxt_o.field   = odd_i;
    unique case (hsel_e'(hsel_i))
      HSEL_GATE:   nxt_o.hmux = hgate;
      HSEL_CURSOR: nxt_o.hmux = cursor;
      default:     nxt_o.hmux = hblank;
    endcase
    unique case (vsel_e'(vsel_i))
      VSEL_GATE: nxt_o.vmux = vgate;
      VSEL_IRQ:  nxt_o.vmux = virq;
      default:   nxt_o.vmux = hsync;
    endcase
  end
endmodule

// File: rtl/vsg_sync_gen.sv
module vsg_sync_gen
  import vsg_pkg::*;
#(
  parameter int W            = 12,
  parameter int EQ_HALVES    = 6,
  parameter bit RUN_ON_CLEAR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] h_total_i,
  input  logic [W-1:0] h_sync_w_i,
  input  logic [W-1:0] h_blank_on_i,
  input  logic [W-1:0] h_blank_off_i,
  input  logic [W-1:0] h_cursor_i,
  input  logic [W-1:0] v_total_i,
  input  logic [W-1:0] v_sync_on_i,
  input  logic [W-1:0] v_sync_off_i,
  input  logic [W-1:0] v_blank_on_i,
  input  logic [W-1:0] v_blank_off_i,
  input  logic [W-1:0] v_cursor_i,
  input  logic         interlace_i,
  input  logic         comp_sync_i,
  input  logic         comp_blank_i,
  input  logic         eqser_en_i,
  input  logic [1:0]   hsel_i,
  input  logic [1:0]   vsel_i,
  output logic         vcsync_o,
  output logic         vcblank_o,
  output logic         hmux_o,
  output logic         vmux_o,
  output logic         field_o
);
  logic         run_q;
  logic [W-1:0] hcnt, hh;
  logic         line_end, second, odd;
  logic [W+1:0] fhp;
  vsg_out_t     nxt, out_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= RUN_ON_CLEAR;
    else if (start_i) run_q <= 1'b1;
  end

  vsg_hcnt #(.W(W)) u_hcnt (
    .clk_i, .rst_ni, .en_i(run_q), .h_total_i,
    .hcnt_o(hcnt), .line_end_o(line_end), .second_o(second), .hh_o(hh)
  );

  vsg_vcnt #(.W(W)) u_vcnt (
    .clk_i, .rst_ni, .en_i(run_q), .line_end_i(line_end), .second_i(second),
    .interlace_i, .v_total_i, .fhp_o(fhp), .odd_o(odd)
  );

  vsg_decode #(.W(W), .EQ_HALVES(EQ_HALVES)) u_dec (
    .h_total_lsb_ok_i(1'b1), .h_total_i, .hcnt_i(hcnt), .hh_i(hh),
    .fhp_i(fhp), .odd_i(odd),
    .h_sync_w_i, .h_blank_on_i, .h_blank_off_i, .h_cursor_i,
    .v_sync_on_i, .v_sync_off_i, .v_blank_on_i, .v_blank_off_i, .v_cursor_i,
    .comp_sync_i, .comp_blank_i, .eqser_en_i, .hsel_i, .vsel_i,
    .nxt_o(nxt)
  );

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    out_q <= VSG_OUT_RST;
    else if (run_q) out_q <= nxt;
  end

  assign vcsync_o  = out_q.vcsync;
  assign vcblank_o = out_q.vcblank;
  assign hmux_o    = out_q.hmux;
  assign vmux_o    = out_q.vmux;
  assign field_o   = out_q.field;
endmodule

// File: rtl/vsg_sync_gen_chk.sv
module vsg_sync_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_q,
  input logic       interlace_i,
  input logic [1:0] hsel_i,
  input logic [1:0] vsel_i,
  input logic       vcsync_o,
  input logic       vcblank_o,
  input logic       hmux_o,
  input logic       vmux_o,
  input logic       field_o
);
  // R2: a halted block holds every output
  assert_halt_holds_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !run_q |=> ($stable(vcsync_o) && $stable(vcblank_o) && $stable(hmux_o) &&
                $stable(vmux_o) && $stable(field_o)));

  // R2: once started, counting never stops until clear
  assert_run_sticky_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);

  // R6: progressive mode keeps the field flag high
  assert_field_high_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!interlace_i && !$past(interlace_i)) |-> field_o);

  // R11: vertical interrupt is a single-clock pulse
  assert_irq_pulse_R11: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (run_q && vmux_o && $past(vsel_i) == 2'd2) |=> (!vmux_o || $past(vsel_i) != 2'd2));

  // R10: line gate is a single-clock pulse
  assert_gate_pulse_R10: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (run_q && hmux_o && $past(hsel_i) == 2'd1) |=> (!hmux_o || $past(hsel_i) != 2'd1));
endmodule

bind vsg_sync_gen vsg_sync_gen_chk u_vsg_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_q(run_q), .interlace_i(interlace_i),
  .hsel_i(hsel_i), .vsel_i(vsel_i), .vcsync_o(vcsync_o), .vcblank_o(vcblank_o),
  .hmux_o(hmux_o), .vmux_o(vmux_o), .field_o(field_o)
);

// File: tb/vsg_sync_gen_bench.sv
module vsg_sync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int HT = 20, HSW = 4, HBON = 16, HBOFF = 6, HC = 7;
  localparam int VT = 9, VSON = 3, VSOFF = 4, VBON = 6, VBOFF = 1, VC = 5;
  localparam int EQ = 6;
  localparam int NCYC = 800;
  localparam int NROWS = 7;

  typedef struct packed {
    logic        il, cs, cb, eq;
    logic [1:0]  hsl, vsl;
    logic [95:0] tag;
  } row_t;

  // il cs cb eq hsel vsel tag
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, "R3 R4 R6"},   // progressive, separate
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd1, "R7 R9 R10"},  // xor composite, gates
    '{1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2, "R5 R11"},     // interlace, cursor, irq
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, "R5 R8"},      // interlace, shaped composite
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 2'd2, "R8 R11"},     // progressive, shaped
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 2'd3, "R10 R11"},    // select code 3
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd0, "R8 R9"}       // shaping ignored without composite
  };

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, start_h = 1'b0;
  logic interlace_i, comp_sync_i, comp_blank_i, eqser_en_i;
  logic [1:0] hsel_i, vsel_i;
  logic vcsync_o, vcblank_o, hmux_o, vmux_o, field_o;
  logic h_vcsync, h_vcblank, h_hmux, h_vmux, h_field;
  int vectors = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vsg_sync_gen u_vsg_sync_gen (
    .clk_i(clk), .rst_ni, .start_i,
    .h_total_i(W'(HT)), .h_sync_w_i(W'(HSW)), .h_blank_on_i(W'(HBON)),
    .h_blank_off_i(W'(HBOFF)), .h_cursor_i(W'(HC)),
    .v_total_i(W'(VT)), .v_sync_on_i(W'(VSON)), .v_sync_off_i(W'(VSOFF)),
    .v_blank_on_i(W'(VBON)), .v_blank_off_i(W'(VBOFF)), .v_cursor_i(W'(VC)),
    .interlace_i, .comp_sync_i, .comp_blank_i, .eqser_en_i, .hsel_i, .vsel_i,
    .vcsync_o, .vcblank_o, .hmux_o, .vmux_o, .field_o
  );

  vsg_sync_gen #(.RUN_ON_CLEAR(1'b0)) u_vsg_sync_gen_halt (
    .clk_i(clk), .rst_ni, .start_i(start_h),
    .h_total_i(W'(HT)), .h_sync_w_i(W'(HSW)), .h_blank_on_i(W'(HBON)),
    .h_blank_off_i(W'(HBOFF)), .h_cursor_i(W'(HC)),
    .v_total_i(W'(VT)), .v_sync_on_i(W'(VSON)), .v_sync_off_i(W'(VSOFF)),
    .v_blank_on_i(W'(VBON)), .v_blank_off_i(W'(VBOFF)), .v_cursor_i(W'(VC)),
    .interlace_i, .comp_sync_i, .comp_blank_i, .eqser_en_i, .hsel_i, .vsel_i,
    .vcsync_o(h_vcsync), .vcblank_o(h_vcblank), .hmux_o(h_hmux),
    .vmux_o(h_vmux), .field_o(h_field)
  );

  // expected {vcsync, vcblank, hmux, vmux, field} at raster position p
  function automatic logic [4:0] ref_out(int p, row_t r);
    int half, h, lines, ln, sec, fpos, fhp, hh;
    logic odd, hs, hb, vsy, vb, eqz, csr, hm, vm;
    half  = HT / 2;
    h     = p % HT;
    lines = r.il ? 2 * VT + 1 : VT;
    ln    = (p / HT) % lines;
    sec   = (h >= half) ? 1 : 0;
    fpos  = 2 * ln + sec;
    odd   = !r.il || fpos < 2 * VT + 1;
    fhp   = odd ? fpos : fpos - (2 * VT + 1);
    hh    = sec ? h - half : h;
    hs    = h < HSW;
    hb    = h >= HBON || h < HBOFF;
    vsy   = fhp >= 2 * VSON && fhp < 2 * VSOFF;
    vb    = fhp >= 2 * VBON || fhp < 2 * VBOFF;
    eqz   = (fhp + EQ >= 2 * VSON && fhp < 2 * VSON) ||
            (fhp >= 2 * VSOFF && fhp < 2 * VSOFF + EQ);
    if (r.eq) csr = vsy ? (hh < half - HSW) : (eqz ? (hh < HSW / 2) : hs);
    else      csr = hs ^ vsy;
    case (r.hsl)
      2'd1:    hm = (h == 0);
      2'd2:    hm = (h == HC) && (fhp / 2 == VC);
      default: hm = hb;
    endcase
    case (r.vsl)
      2'd1:    vm = fhp < 2;
      2'd2:    vm = (fhp == 2 * VBON) && (hh == 0);
      default: vm = hs;
    endcase
    return {r.cs ? csr : vsy, r.cb ? (hb | vb) : vb, hm, vm, odd};
  endfunction

  task automatic check(input logic [4:0] got, input logic [4:0] exp,
                       input logic [95:0] tag, input int n);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s step %0d: got %b expected %b", tag, n, got, exp);
    end
  endtask

  task automatic drive_row(input row_t r);
    interlace_i  = r.il;
    comp_sync_i  = r.cs;
    comp_blank_i = r.cb;
    eqser_en_i   = r.eq;
    hsel_i       = r.hsl;
    vsel_i       = r.vsl;
  endtask

  task automatic clear_and_release(input row_t r);
    rst_ni = 1'b0;
    drive_row(r);
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1: reset values before the first falling edge
    check({vcsync_o, vcblank_o, hmux_o, vmux_o, field_o}, 5'b00001, "R1 reset", 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    drive_row(ROWS[0]);
    for (int i = 0; i < NROWS; i++) begin
      clear_and_release(ROWS[i]);
      for (int n = 1; n <= NCYC; n++) begin
        @(posedge clk);
        check({vcsync_o, vcblank_o, hmux_o, vmux_o, field_o},
              ref_out(n - 1, ROWS[i]), ROWS[i].tag, n);
        // R2: halted build keeps reset outputs without a start
        if (i == 0)
          check({h_vcsync, h_vcblank, h_hmux, h_vmux, h_field}, 5'b00001, "R2 halted", n);
      end
    end

    // R2: start strobe on the halted build
    clear_and_release(ROWS[3]);
    repeat (30) @(posedge clk);
    check({h_vcsync, h_vcblank, h_hmux, h_vmux, h_field}, 5'b00001, "R2 pre-start", 0);
    start_h = 1'b1;
    @(posedge clk);
    start_h = 1'b0;
    check({h_vcsync, h_vcblank, h_hmux, h_vmux, h_field}, 5'b00001, "R2 start edge", 0);
    for (int n = 0; n < 400; n++) begin
      @(posedge clk);
      check({h_vcsync, h_vcblank, h_hmux, h_vmux, h_field}, ref_out(n, ROWS[3]),
            "R2 started", n);
    end

    // R1: asynchronous clear mid-frame (field_o low in the even field here)
    clear_and_release(ROWS[2]);
    repeat (250) @(posedge clk);
    check({1'b0, 1'b0, 1'b0, 1'b0, field_o}, 5'b00000, "R5 even field", 250);
    #1 rst_ni = 1'b0;
    #1 check({vcsync_o, vcblank_o, hmux_o, vmux_o, field_o}, 5'b00001, "R1 async clear", 0);
    @(posedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule